// File: doc/BRIEF.md
# TDM Timeslot Transfer Request Unit

This block connects a 12-slot time-division multiplexed frame bus to a processor that moves data with event-triggered DMA channels. Bytes received on the upstream and downstream lines are written into capture buffers. Bytes to be sent on either line are played out from playout buffers. Each line and direction has a pair of 12-byte buffers. A frame-sync pulse swaps the roles of each pair. The buffer just filled becomes the held buffer, and the processor can service the held buffer for almost one whole frame.

Eight mask channels pick the timeslots to move. Each channel holds a programmed 12-bit timeslot bitmap, a line bit and a direction bit. It also keeps a working copy of the bitmap.

While transfers are globally enabled, a channel with working bits set raises its request for the lowest set timeslot and presents that slot index. An acknowledge clears that bit, and the request then moves on to the next set slot. The working copy is reloaded from the programmed bitmap by a frame-sync pulse, but only when it is already empty.

The processor reaches all of this through a register port with a byte-wide path into the held buffers. DMA transfers are emulated through that path.

Top module: `tdm_xfer_unit`

## Requirements
- R1: After reset the enable bit, every programmed mask, every working copy and every held buffer byte read 0, and no request is raised.
- R2: Writing address 0x10+c stores channel c's mask: bitmap in bits 11:0, line in bit 12 (0 upstream, 1 downstream), direction in bit 13 (0 read from bus, 1 write to bus). The same address reads it back. reqPair[2c+1:2c] shows {line, direction}. Address 0x20+c reads the working copy, and address 0x00 bit 0 is the global enable.
- R3: A frame-sync pulse while a channel's working copy is all zero loads the programmed bitmap into it on that clock edge.
- R4: A frame-sync pulse while any working bit is set leaves the working copy unchanged, apart from a bit cleared by a same-cycle acknowledge.
- R5: A channel whose working copy is non-zero raises reqOut[c] while enabled, and reqSlot[4c+3:4c] gives the lowest set working bit.
- R6: An acknowledge on ack[c] during a raised request clears exactly that slot's working bit. The request moves to the next set bit, or drops when none is left.
- R7: While the global enable is 0 no request is raised, and working copies keep their value.
- R8: Bytes presented with slotValid at slot i on rxUpByte and rxDnByte land in the capture buffers. After the next frame sync they read at address 0x80|line<<5|i with the direction bit 4 at 0.
- R9: Bytes written at address 0x90|line<<5|i enter the held write buffer of that line. After the next frame sync they appear on txUpByte or txDnByte while slotIdx is i.
- R10: The two lines and two directions use separate buffers, so data on one never shows in another.
- R11: Capture of a following frame before the next frame sync leaves the held buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame-sync pulse, one cycle |
| slotValid | input | 1 | Receive bytes valid for slotIdx |
| slotIdx | input | 4 | Current timeslot index |
| rxUpByte | input | 8 | Byte received on the upstream line |
| rxDnByte | input | 8 | Byte received on the downstream line |
| txUpByte | output | 8 | Playout byte for the upstream line at slotIdx |
| txDnByte | output | 8 | Playout byte for the downstream line at slotIdx |
| regWe | input | 1 | Register port write strobe |
| regAddr | input | 8 | Register port address |
| regWdata | input | 14 | Register port write data |
| regRdata | output | 14 | Register port read data, combinational |
| reqOut | output | 8 | Per-channel transfer request |
| reqSlot | output | 32 | Per-channel 4-bit slot index of the pending transfer |
| reqPair | output | 16 | Per-channel {line, direction} |
| ack | input | 8 | Per-channel transfer acknowledge |

## Verification
Some rules are checked on every cycle: a blocked reload never changes a working copy, each acknowledge removes exactly one working bit, a presented slot index always points to a set working bit, no request appears while disabled, and every frame sync flips the buffer bank. The bench scenarios are needed for the rest: the register layout, the reload sequence across several frames, and the data paths. These include where a captured byte reappears after the swap, playout of written bytes on the right line, separation of the four buffers, and a held buffer that stays put while the next frame is captured.

// File: rtl/tdm_xfer_pkg.sv
package tdm_xfer_pkg;
  localparam int NUM_SLOTS = 12;
  localparam int SLOT_W    = 4;
  localparam int DATA_W    = 8;
  localparam int NUM_PAIRS = 4;   // {line, dir}

  // strobes from control to datapath
  typedef struct packed {
    logic              swap;
    logic              hostWe;
    logic [1:0]        hostPair;
    logic [SLOT_W-1:0] hostSlot;
    logic [DATA_W-1:0] hostData;
  } dpStrobe_t;
endpackage

// File: rtl/tdm_xfer_dp.sv
module tdm_xfer_dp
  import tdm_xfer_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              slotValid,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic [DATA_W-1:0] rxUp,
  input  logic [DATA_W-1:0] rxDn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txUp,
  output logic [DATA_W-1:0] txDn
);
  localparam int PAIR_UP_RD = 0;
  localparam int PAIR_UP_WR = 1;
  localparam int PAIR_DN_RD = 2;
  localparam int PAIR_DN_WR = 3;

  logic [DATA_W-1:0] mem [NUM_PAIRS][2][SLOTS];
  logic              heldBank;
  logic              liveBank;

  assign liveBank = ~heldBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBank <= 1'b0;
      for (int p = 0; p < NUM_PAIRS; p++)
        for (int b = 0; b < 2; b++)
          for (int s = 0; s < SLOTS; s++)
            mem[p][b][s] <= '0;
    end else begin
      if (strb.swap) heldBank <= ~heldBank;
      if (slotValid && (int'(slotIdx) < SLOTS)) begin
        mem[PAIR_UP_RD][liveBank][slotIdx] <= rxUp;
        mem[PAIR_DN_RD][liveBank][slotIdx] <= rxDn;
      end
      if (strb.hostWe && (int'(strb.hostSlot) < SLOTS))
        mem[strb.hostPair][heldBank][strb.hostSlot] <= strb.hostData;
    end
  end

  always_comb begin
    rdData = '0;
    txUp   = '0;
    txDn   = '0;
    if (int'(strb.hostSlot) < SLOTS) rdData = mem[strb.hostPair][heldBank][strb.hostSlot];
    if (int'(slotIdx) < SLOTS) begin
      txUp = mem[PAIR_UP_WR][liveBank][slotIdx];
      txDn = mem[PAIR_DN_WR][liveBank][slotIdx];
    end
  end

  // R8
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.swap |=> (heldBank != $past(heldBank)));
endmodule

// File: rtl/tdm_xfer_ctl.sv
module tdm_xfer_ctl
  import tdm_xfer_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int SLOTS    = NUM_SLOTS,
  parameter int ADDR_W   = 8,
  parameter int REG_W    = SLOTS + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fsync,
  input  logic                   regWe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [REG_W-1:0]       regWdata,
  input  logic [DATA_W-1:0]      bufRdData,
  input  logic [CHANNELS-1:0]    ack,
  output dpStrobe_t              strb,
  output logic                   enable,
  output logic [REG_W-1:0]       regRdata,
  output logic [CHANNELS-1:0]    reqOut,
  output logic [CHANNELS*SLOT_W-1:0] reqSlot,
  output logic [CHANNELS*2-1:0]  reqPair
);
  localparam int CH_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam int LINE_BIT = SLOTS;
  localparam int DIR_BIT  = SLOTS + 1;

  logic [SLOTS-1:0] maskArr [CHANNELS];
  logic [SLOTS-1:0] workArr [CHANNELS];
  logic [1:0]       pairArr [CHANNELS];

  logic bufSel, ctrlSel, maskSel, workSel;
  assign bufSel  = regAddr[7] & ~regAddr[6];
  assign ctrlSel = (regAddr == '0);
  assign maskSel = (regAddr[7:4] == 4'h1) && (int'(regAddr[3:0]) < CHANNELS);
  assign workSel = (regAddr[7:4] == 4'h2) && (int'(regAddr[3:0]) < CHANNELS);

  assign strb.swap     = fsync;
  assign strb.hostWe   = regWe & bufSel;
  assign strb.hostPair = {regAddr[5], regAddr[4]};
  assign strb.hostSlot = regAddr[3:0];
  assign strb.hostData = regWdata[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enable <= 1'b0;
    else if (regWe && ctrlSel) enable <= regWdata[0];
  end

  function automatic logic [SLOT_W-1:0] lowestSet(input logic [SLOTS-1:0] v);
    lowestSet = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (v[i]) lowestSet = SLOT_W'(i);
  endfunction

  for (genvar c = 0; c < CHANNELS; c++) begin : gChan
    logic [SLOTS-1:0]  maskQ;
    logic [SLOTS-1:0]  workQ;
    logic              lineQ, dirQ;
    logic              reqLoc;
    logic [SLOT_W-1:0] slotLoc;
    logic              wrHit;

    assign wrHit   = regWe && maskSel && (regAddr[CH_W-1:0] == CH_W'(c));
    assign slotLoc = lowestSet(workQ);
    assign reqLoc  = enable && (workQ != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ <= '0;
        lineQ <= 1'b0;
        dirQ  <= 1'b0;
      end else if (wrHit) begin
        maskQ <= regWdata[SLOTS-1:0];
        lineQ <= regWdata[LINE_BIT];
        dirQ  <= regWdata[DIR_BIT];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        workQ <= '0;
      else if (fsync && workQ == '0)    workQ <= maskQ;
      else if (ack[c] && reqLoc)        workQ <= workQ & ~(SLOTS'(1) << slotLoc);
    end

    assign maskArr[c] = maskQ;
    assign workArr[c] = workQ;
    assign pairArr[c] = {lineQ, dirQ};
    assign reqOut[c]  = reqLoc;
    assign reqSlot[c*SLOT_W +: SLOT_W] = slotLoc;
    assign reqPair[c*2 +: 2] = {lineQ, dirQ};

    // R4
    blocked_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fsync && workQ != '0 && !(ack[c] && reqLoc)) |=> (workQ == $past(workQ)));
    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ack[c] && reqLoc) |=> ($countones(workQ) == $countones($past(workQ)) - 1));
    // R5
    slot_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      reqLoc |-> workQ[slotLoc]);
  end

  always_comb begin
    regRdata = '0;
    if (ctrlSel)      regRdata[0] = enable;
    else if (maskSel) regRdata = {pairArr[regAddr[CH_W-1:0]][0], pairArr[regAddr[CH_W-1:0]][1],
                                  maskArr[regAddr[CH_W-1:0]]};
    else if (workSel) regRdata[SLOTS-1:0] = workArr[regAddr[CH_W-1:0]];
    else if (bufSel)  regRdata[DATA_W-1:0] = bufRdData;
  end
endmodule

// File: rtl/tdm_xfer_unit.sv
module tdm_xfer_unit
  import tdm_xfer_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int SLOTS    = NUM_SLOTS,
  parameter int REG_W    = SLOTS + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fsync,
  input  logic                       slotValid,
  input  logic [SLOT_W-1:0]          slotIdx,
  input  logic [DATA_W-1:0]          rxUpByte,
  input  logic [DATA_W-1:0]          rxDnByte,
  output logic [DATA_W-1:0]          txUpByte,
  output logic [DATA_W-1:0]          txDnByte,
  input  logic                       regWe,
  input  logic [7:0]                 regAddr,
  input  logic [REG_W-1:0]           regWdata,
  output logic [REG_W-1:0]           regRdata,
  output logic [CHANNELS-1:0]        reqOut,
  output logic [CHANNELS*SLOT_W-1:0] reqSlot,
  output logic [CHANNELS*2-1:0]      reqPair,
  input  logic [CHANNELS-1:0]        ack
);
  dpStrobe_t         strb;
  logic [DATA_W-1:0] bufRdData;
  logic              enable;

  tdm_xfer_ctl #(.CHANNELS(CHANNELS), .SLOTS(SLOTS), .ADDR_W(8), .REG_W(REG_W)) uCtl (
    .clk(clk), .rstN(rstN), .fsync(fsync), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .bufRdData(bufRdData), .ack(ack), .strb(strb),
    .enable(enable), .regRdata(regRdata), .reqOut(reqOut), .reqSlot(reqSlot),
    .reqPair(reqPair)
  );

  tdm_xfer_dp #(.SLOTS(SLOTS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotValid(slotValid), .slotIdx(slotIdx),
    .rxUp(rxUpByte), .rxDn(rxDnByte), .rdData(bufRdData), .txUp(txUpByte),
    .txDn(txDnByte)
  );

  // R7
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (reqOut == '0));
endmodule

// File: tb/sim_tdm_xfer_unit.sv
`timescale 1ns/1ps
module sim_tdm_xfer_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fsync = 1'b0;
  logic        slotValid = 1'b0;
  logic [3:0]  slotIdx = '0;
  logic [7:0]  rxUpByte = '0, rxDnByte = '0;
  logic [7:0]  txUpByte, txDnByte;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [13:0] regWdata = '0;
  logic [13:0] regRdata;
  logic [7:0]  reqOut;
  logic [31:0] reqSlot;
  logic [15:0] reqPair;
  logic [7:0]  ack = '0;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tdm_xfer_unit u0 (
    .clk(clk), .rstN(rstN), .fsync(fsync), .slotValid(slotValid), .slotIdx(slotIdx),
    .rxUpByte(rxUpByte), .rxDnByte(rxDnByte), .txUpByte(txUpByte), .txDnByte(txDnByte),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .reqOut(reqOut), .reqSlot(reqSlot), .reqPair(reqPair), .ack(ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [13:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [13:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic pulseSync();
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
  endtask

  task automatic pulseAck(input int c);
    @(negedge clk); ack[c] = 1'b1;
    @(negedge clk); ack[c] = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] upBase, input logic [7:0] dnBase);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); slotValid = 1'b1; slotIdx = 4'(i);
      rxUpByte = upBase + 8'(i); rxDnByte = dnBase + 8'(i);
    end
    @(negedge clk); slotValid = 1'b0;
  endtask

  task automatic testReset();
    logic [13:0] d;
    regRead(8'h00, d); chk("R1 enable", 32'(d), 0);
    regRead(8'h12, d); chk("R1 mask", 32'(d), 0);
    regRead(8'h25, d); chk("R1 work", 32'(d), 0);
    regRead(8'h83, d); chk("R1 buffer", 32'(d), 0);
    chk("R1 reqOut", 32'(reqOut), 0);
  endtask

  task automatic testMaskRegs();
    logic [13:0] d;
    regWrite(8'h13, 14'h33A5);
    regRead(8'h13, d); chk("R2 mask readback", 32'(d), 32'h33A5);
    chk("R2 reqPair ch3", 32'(reqPair[7:6]), 32'h3);
    regRead(8'h23, d); chk("R2 work untouched", 32'(d), 0);
    regWrite(8'h13, 14'h0);
  endtask

  task automatic testReload();
    logic [13:0] d;
    regWrite(8'h10, 14'h0024);
    pulseSync();
    regRead(8'h20, d); chk("R3 reload on empty", 32'(d), 32'h024);
    chk("R7 no req disabled", 32'(reqOut), 0);
    regWrite(8'h10, 14'h0800);
    pulseSync();
    regRead(8'h20, d); chk("R4 reload blocked", 32'(d), 32'h024);
    regRead(8'h20, d); chk("R7 work held while disabled", 32'(d), 32'h024);
    regWrite(8'h00, 14'h1);
    chk("R5 req raised", 32'(reqOut[0]), 1);
    chk("R5 lowest slot", 32'(reqSlot[3:0]), 2);
    pulseAck(0);
    chk("R6 next slot", 32'(reqSlot[3:0]), 5);
    chk("R6 still req", 32'(reqOut[0]), 1);
    pulseAck(0);
    chk("R6 req drops", 32'(reqOut[0]), 0);
    regRead(8'h20, d); chk("R6 work empty", 32'(d), 0);
    pulseSync();
    regRead(8'h20, d); chk("R3 reload new mask", 32'(d), 32'h800);
    chk("R5 slot 11", 32'(reqSlot[3:0]), 11);
    regWrite(8'h00, 14'h0);
    chk("R7 disable drops req", 32'(reqOut), 0);
  endtask

  task automatic testCapture();
    logic [13:0] d;
    sendFrame(8'h10, 8'hA0);
    pulseSync();
    regRead(8'h83, d); chk("R8 up capture", 32'(d), 32'h13);
    regRead(8'hA3, d); chk("R8 dn capture", 32'(d), 32'hA3);
    regRead(8'h8B, d); chk("R8 up last slot", 32'(d), 32'h1B);
    regRead(8'h93, d); chk("R10 up wr separate", 32'(d), 0);
    sendFrame(8'h40, 8'h60);
    regRead(8'h83, d); chk("R11 held stable up", 32'(d), 32'h13);
    regRead(8'hA7, d); chk("R11 held stable dn", 32'(d), 32'hA7);
  endtask

  task automatic testPlayout();
    for (int i = 0; i < 12; i++) begin
      regWrite(8'h90 | 8'(i), 14'(8'h50 + 8'(i)));
      regWrite(8'hB0 | 8'(i), 14'(8'hC0 + 8'(i)));
    end
    pulseSync();
    @(negedge clk); slotIdx = 4'd7; #1;
    chk("R9 tx up", 32'(txUpByte), 32'h57);
    chk("R9 tx dn", 32'(txDnByte), 32'hC7);
    slotIdx = 4'd0; #1;
    chk("R10 tx up slot0", 32'(txUpByte), 32'h50);
    chk("R10 tx dn slot0", 32'(txDnByte), 32'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMaskRegs();
    testReload();
    testCapture();
    testPlayout();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule